// File: doc/BRIEF.md
# OR-Reduction Resolution Pyramid Builder

This block derives a coarser copy of a binary hit image stored as a set of one-bit-wide plane memories. Within each plane it walks the columns in order. It folds every run of `p` neighbouring pixels into a single pixel using a logical OR and writes that pixel into a destination plane memory at the column index divided by `p`. Because the reduction is an OR and not an average, an isolated hit is never lost at the coarser level. Each plane is handled on its own, and the destination has as many planes as the source.

A controller builds a pyramid by running the block repeatedly. The output of one run becomes the source of the next, so that each layer comes from the layer directly below it, and the full-resolution image sits at the base. The reduction factor is picked per run from 2, 4, 8 or 16. A start strobe latches the factor and the source row length. A one-cycle done pulse follows the final destination write. The source memory is read one bit per cycle with one cycle of read latency.

Top module: `pyr_or_reduce`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `src_rd_en_o` and `dst_wr_en_o` are all low.
- R2: The factor is `p = 2 << ratio_sel_i`, so codes 0, 1, 2 and 3 give p = 2, 4, 8 and 16. Destination bit `j` of plane `q` is the OR of source bits `j*p` through `j*p+p-1` of plane `q`.
- R3: The destination row length is ceil(len/p). When len is not a multiple of p, the last output bit ORs only the columns below len. Exactly (planes × ceil(len/p)) writes occur, each to a distinct address below ceil(len/p) in the same plane as its source. Destination addresses at or above that length are never written.
- R4: One source read is issued per cycle. Plane 0 is read first, then the planes in ascending order, and within each plane the columns go 0 to len-1. Every source pixel is read exactly once. Read data is taken from `src_rd_data_i` one cycle after the read is issued.
- R5: For a start sampled at clock edge k, `done_o` is high for exactly one cycle. That cycle follows edge k + planes×len + 1, which is the first cycle after the last write.
- R6: `busy_o` is high from the cycle after an accepted start through the cycle of the final write, and it is low while `done_o` is high.
- R7: A start strobe while `busy_o` is high is ignored. The running job keeps the factor and length latched at its own start.
- R8: A start strobe with `src_len_i` equal to 0 or greater than MAXCOLS is ignored. No read is issued and `busy_o` stays low.
- R9: Layers compose. Reducing by p1 and then reducing that result by p2 gives the same image as a single reduction by p1×p2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled when idle |
| ratio_sel_i | input | 2 | Reduction factor code, p = 2 << code |
| src_len_i | input | LW | Source columns per plane, 1..MAXCOLS |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse after the last write |
| src_rd_en_o | output | 1 | Source read request |
| src_plane_o | output | PW | Source plane index |
| src_addr_o | output | AW | Source column index |
| src_rd_data_i | input | 1 | Source pixel, valid the cycle after the read |
| dst_wr_en_o | output | 1 | Destination write strobe |
| dst_plane_o | output | PW | Destination plane index |
| dst_addr_o | output | AW | Destination column index |
| dst_wr_data_o | output | 1 | Reduced pixel |

## Verification
The hardest case to reach is a final partial group that holds the only hit in its plane. Here a wrong group-end test or a missing write at a plane boundary would silently drop that hit. The bench uses a length of 37 with factor 16 and places single hits at column 36 and at the start of a partial group, while a neighbouring plane stays all zero. A second hard case is a start strobe that arrives mid-job with a different factor and length. The bench raises it a few cycles into a running job and then checks the timing, the write count and the image against the original parameters only.

// File: rtl/pyr_pkg.sv
package pyr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} pyr_state_e;

  // group size for a ratio code: 2, 4, 8, 16
  function automatic logic [31:0] grp_size(input logic [1:0] sel);
    return 32'd2 << sel;
  endfunction

  // destination row length: ceil(len / p)
  function automatic logic [31:0] out_len(input logic [31:0] len, input logic [1:0] sel);
    return (len + grp_size(sel) - 32'd1) >> ({30'd0, sel} + 32'd1);
  endfunction

endpackage

// File: rtl/pyr_rd_seq.sv
module pyr_rd_seq
  import pyr_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int MAXCOLS = 64,
  localparam int PW = (NPLANES > 1) ? $clog2(NPLANES) : 1,
  localparam int AW = (MAXCOLS > 1) ? $clog2(MAXCOLS) : 1,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [1:0]    sel_i,
  input  logic [LW-1:0] len_i,
  output logic          rd_en_o,
  output logic [PW-1:0] rd_plane_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          first_o,
  output logic          last_grp_o,
  output logic          last_all_o,
  output logic [AW-1:0] out_idx_o
);

  logic [AW-1:0] col_q;
  logic [PW-1:0] plane_q;
  logic [AW-1:0] k_mask;
  logic          last_in_plane;

  assign k_mask        = AW'(grp_size(sel_i) - 32'd1);
  assign last_in_plane = (LW'(col_q) == len_i - LW'(1));

  assign rd_en_o    = run_i;
  assign rd_plane_o = plane_q;
  assign rd_addr_o  = col_q;
  assign first_o    = ((col_q & k_mask) == '0);
  assign last_grp_o = ((col_q & k_mask) == k_mask) || last_in_plane;
  assign last_all_o = last_in_plane && (plane_q == PW'(NPLANES - 1));
  assign out_idx_o  = col_q >> ({1'b0, sel_i} + 3'd1);

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      col_q   <= '0;
      plane_q <= '0;
    end else if (run_i) begin
      if (last_in_plane) begin
        col_q   <= '0;
        plane_q <= plane_q + PW'(1);
      end else begin
        col_q <= col_q + AW'(1);
      end
    end
  end

  // R4
  rd_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> (LW'(rd_addr_o) < len_i));

  // R4
  rd_ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && $past(rd_en_o) && $past(rd_plane_o) == rd_plane_o)
      |-> (rd_addr_o == $past(rd_addr_o) + AW'(1)));

endmodule

// File: rtl/pyr_or_acc.sv
module pyr_or_acc
#(
  parameter int PW = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic          last_grp_i,
  input  logic          last_all_i,
  input  logic [PW-1:0] plane_i,
  input  logic [AW-1:0] idx_i,
  input  logic          rd_data_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_plane_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_data_o,
  output logic          done_o
);

  // tag of the read in flight, aligned with the returning data
  logic          v_q, f_q, lg_q, la_q;
  logic [PW-1:0] plane_q;
  logic [AW-1:0] idx_q;
  logic          acc_q;
  logic          done_q;
  logic          merged;

  assign merged     = (f_q ? 1'b0 : acc_q) | rd_data_i;
  assign wr_en_o    = v_q && lg_q;
  assign wr_plane_o = plane_q;
  assign wr_addr_o  = idx_q;
  assign wr_data_o  = merged;
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      f_q     <= 1'b0;
      lg_q    <= 1'b0;
      la_q    <= 1'b0;
      plane_q <= '0;
      idx_q   <= '0;
      acc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      v_q     <= valid_i;
      f_q     <= first_i;
      lg_q    <= last_grp_i;
      la_q    <= last_all_i && valid_i;
      plane_q <= plane_i;
      idx_q   <= idx_i;
      done_q  <= v_q && la_q;
      if (v_q) acc_q <= lg_q ? 1'b0 : merged;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(wr_en_o));

endmodule

// File: rtl/pyr_or_reduce.sv
module pyr_or_reduce
  import pyr_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int MAXCOLS = 64,
  localparam int PW = (NPLANES > 1) ? $clog2(NPLANES) : 1,
  localparam int AW = (MAXCOLS > 1) ? $clog2(MAXCOLS) : 1,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    ratio_sel_i,
  input  logic [LW-1:0] src_len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          src_rd_en_o,
  output logic [PW-1:0] src_plane_o,
  output logic [AW-1:0] src_addr_o,
  input  logic          src_rd_data_i,
  output logic          dst_wr_en_o,
  output logic [PW-1:0] dst_plane_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          dst_wr_data_o
);

  pyr_state_e    state_q;
  logic [1:0]    sel_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] olen_q;
  logic          len_ok;
  logic          accept;
  logic          run;
  logic          rd_first, rd_last_grp, rd_last_all;
  logic [AW-1:0] rd_idx;

  assign len_ok = (src_len_i != '0) && (src_len_i <= LW'(MAXCOLS));
  assign accept = start_i && (state_q == ST_IDLE) && len_ok;
  assign run    = (state_q == ST_RUN);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      len_q   <= '0;
      olen_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          sel_q   <= ratio_sel_i;
          len_q   <= src_len_i;
          olen_q  <= LW'(out_len(32'(src_len_i), ratio_sel_i));
        end
        ST_RUN:  if (rd_last_all) state_q <= ST_WAIT;
        ST_WAIT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pyr_rd_seq #(.NPLANES(NPLANES), .MAXCOLS(MAXCOLS)) rd_seq_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .run_i      (run),
    .sel_i      (sel_q),
    .len_i      (len_q),
    .rd_en_o    (src_rd_en_o),
    .rd_plane_o (src_plane_o),
    .rd_addr_o  (src_addr_o),
    .first_o    (rd_first),
    .last_grp_o (rd_last_grp),
    .last_all_o (rd_last_all),
    .out_idx_o  (rd_idx)
  );

  pyr_or_acc #(.PW(PW), .AW(AW)) or_acc_i (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (src_rd_en_o),
    .first_i    (rd_first),
    .last_grp_i (rd_last_grp),
    .last_all_i (rd_last_all),
    .plane_i    (src_plane_o),
    .idx_i      (rd_idx),
    .rd_data_i  (src_rd_data_i),
    .wr_en_o    (dst_wr_en_o),
    .wr_plane_o (dst_plane_o),
    .wr_addr_o  (dst_addr_o),
    .wr_data_o  (dst_wr_data_o),
    .done_o     (done_o)
  );

  // R3
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    dst_wr_en_o |-> (LW'(dst_addr_o) < olen_q));

  // R6
  wr_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dst_wr_en_o |-> busy_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(sel_q) && $stable(len_q)));

  // R8
  bad_len_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && (src_len_i == '0)) |=> !busy_o);

endmodule

// File: tb/pyr_or_reduce_tb.sv
module pyr_or_reduce_tb_top;

  localparam int NP = 4;
  localparam int MC = 64;
  localparam int PW = 2;
  localparam int AW = 6;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    ratio_sel_i = '0;
  logic [LW-1:0] src_len_i = '0;
  logic          busy_o, done_o, src_rd_en_o, dst_wr_en_o, dst_wr_data_o;
  logic [PW-1:0] src_plane_o, dst_plane_o;
  logic [AW-1:0] src_addr_o, dst_addr_o;
  logic          src_rd_data_i;

  logic src_mem [NP][MC];
  logic dst_got [NP][MC];
  logic orig    [NP][MC];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pyr_or_reduce #(.NPLANES(NP), .MAXCOLS(MC)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .ratio_sel_i(ratio_sel_i),
    .src_len_i(src_len_i), .busy_o(busy_o), .done_o(done_o),
    .src_rd_en_o(src_rd_en_o), .src_plane_o(src_plane_o), .src_addr_o(src_addr_o),
    .src_rd_data_i(src_rd_data_i), .dst_wr_en_o(dst_wr_en_o), .dst_plane_o(dst_plane_o),
    .dst_addr_o(dst_addr_o), .dst_wr_data_o(dst_wr_data_o)
  );

  // source plane memory, one cycle read latency
  always_ff @(posedge clk) begin
    if (src_rd_en_o) src_rd_data_i <= src_mem[src_plane_o][src_addr_o];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    for (int q = 0; q < NP; q++)
      for (int c = 0; c < MC; c++)
        case (kind)
          0: src_mem[q][c] = ((c * 13 + q * 7 + 3) % 5) == 0;
          1: src_mem[q][c] = (c == q * 9 + 2);
          2: src_mem[q][c] = (q == 0) ? (c == 36) : (q == 2) ? (c == 32) : 1'b0;
          default: src_mem[q][c] = 1'b1;
        endcase
  endtask

  // one job; poke != 0 raises a conflicting start while busy
  task automatic run_job(input logic [1:0] sel, input int len, input string req, input bit poke);
    int p = 2 << sel;
    int olen = (len + p - 1) / p;
    int tot = NP * len;
    int k = 0, rp = 0, rc = 0, reads = 0, writes = 0, rd_bad = 0, busy_bad = 0, wr_bad = 0;
    logic exp_bit;
    for (int q = 0; q < NP; q++) for (int c = 0; c < MC; c++) dst_got[q][c] = 1'b1;
    @(negedge clk);
    start_i = 1'b1; ratio_sel_i = sel; src_len_i = LW'(len);
    while (!done_o && k < tot + 20) begin
      @(negedge clk);
      k++;
      if (k == 1) start_i = 1'b0;
      if (poke && k == 3) begin start_i = 1'b1; ratio_sel_i = sel ^ 2'd3; src_len_i = LW'(5); end
      if (poke && k == 4) start_i = 1'b0;
      if (!done_o && !busy_o) busy_bad++;
      if (src_rd_en_o) begin
        reads++;
        if (int'(src_plane_o) != rp || int'(src_addr_o) != rc) rd_bad++;
        rc++;
        if (rc == len) begin rc = 0; rp++; end
      end
      if (dst_wr_en_o) begin
        writes++;
        if (int'(dst_addr_o) >= olen) wr_bad++;
        else dst_got[dst_plane_o][dst_addr_o] = dst_wr_data_o;
      end
    end
    check(k == tot + 2, {req, " R5 done timing"}, k, tot + 2);
    check(!busy_o, {req, " R6 busy low at done"}, busy_o, 0);
    check(busy_bad == 0, {req, " R6 busy during job"}, busy_bad, 0);
    check(reads == tot && rd_bad == 0, {req, " R4 read order"}, reads + 1000 * rd_bad, tot);
    check(writes == NP * olen && wr_bad == 0, {req, " R3 write count"}, writes, NP * olen);
    for (int q = 0; q < NP; q++) begin
      int bad = 0;
      for (int j = 0; j < olen; j++) begin
        exp_bit = 1'b0;
        for (int c = j * p; c < j * p + p && c < len; c++) exp_bit |= src_mem[q][c];
        if (dst_got[q][j] !== exp_bit) bad++;
      end
      for (int j = olen; j < MC; j++) if (dst_got[q][j] !== 1'b1) bad++;
      check(bad == 0, {req, " R2 R3 plane image"}, bad, 0);
    end
    @(negedge clk);
    check(!done_o, {req, " R5 done single cycle"}, done_o, 0);
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o, "R1 busy/done after reset", int'(busy_o) + int'(done_o), 0);
    check(!src_rd_en_o && !dst_wr_en_o, "R1 strobes after reset",
          int'(src_rd_en_o) + int'(dst_wr_en_o), 0);
  endtask

  task automatic t_bad_len(input int len);
    int seen = 0;
    @(negedge clk);
    start_i = 1'b1; ratio_sel_i = 2'd0; src_len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy_o || src_rd_en_o) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 bad length ignored", seen, 0);
  endtask

  task automatic t_chain;
    int bad = 0;
    logic e;
    fill(0);
    for (int q = 0; q < NP; q++) for (int c = 0; c < MC; c++) orig[q][c] = src_mem[q][c];
    run_job(2'd0, 64, "R9 layer1 p2", 1'b0);
    for (int q = 0; q < NP; q++) for (int c = 0; c < MC; c++)
      src_mem[q][c] = (c < 32) ? dst_got[q][c] : 1'b0;
    run_job(2'd1, 32, "R9 layer2 p4", 1'b0);
    for (int q = 0; q < NP; q++)
      for (int j = 0; j < 8; j++) begin
        e = 1'b0;
        for (int c = j * 8; c < j * 8 + 8; c++) e |= orig[q][c];
        if (dst_got[q][j] !== e) bad++;
      end
    check(bad == 0, "R9 two layers equal one p8 layer", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    fill(0); run_job(2'd0, 64, "R2 p2 full row", 1'b0);
    fill(1); run_job(2'd1, 64, "R2 p4 single hits", 1'b0);
    fill(2); run_job(2'd3, 37, "R3 p16 partial group", 1'b0);
    fill(0); run_job(2'd2, 1,  "R3 p8 len1", 1'b0);
    fill(3); run_job(2'd1, 63, "R2 p4 all ones", 1'b0);
    fill(0); run_job(2'd0, 20, "R7 start while busy", 1'b1);
    t_bad_len(0);
    t_bad_len(65);
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule